// File: doc/BRIEF.md
# Operand Collector with Zero and Immediate Substitution

This block sits in front of one function unit. It takes an issued operation and fetches that operation's source operands. For every source slot that needs a value from the register file, it raises a read request and holds it. It latches the returned data on the cycle the matching grant arrives. Once every slot the operation needs is filled, it tells the function unit that the operands are ready.

Two slots can skip the register file. Slot 0 can be forced to all zeros, and slot 1 can take an immediate value supplied with the operation. A substituted slot never raises its read request. A per-operation use mask marks slots the operation does not touch; those slots count as satisfied at once.

The six slots have a fixed order and fixed widths: two integer operands, one full condition word, then three condition fields. A go pulse from the function unit releases the collector back to idle.

Top module: `opc_operand_fetch`

## Requirements
- R1: When `op_zero` is set at issue, slot 0 (bits 63:0 of `src_o`) holds all zeros and `rd_req[0]` is never raised for that operation, whatever its use bit.
- R2: When `op_imm_ok` is set at issue and slot 1 is used, slot 1 (bits 127:64 of `src_o`) holds `op_imm`, and `rd_req[1]` is never raised for that operation.
- R3: Zero forcing affects only slot 0 and immediate substitution affects only slot 1. With both flags set, slots 2 to 5 are still requested and read normally.
- R4: The slot layout on `rd_data` and `src_o` is fixed. Slot 0 is bits 63:0 and slot 1 is bits 127:64 (64-bit integer operands). Slot 2 is bits 159:128 (32-bit condition word). Slots 3, 4 and 5 are bits 163:160, 167:164 and 171:168 (4-bit fields, each an inclusive 0:3 range). Bit i of `rd_req`, `rd_gnt` and `op_use` belongs to slot i.
- R5: From the cycle after issue, each used slot that is not substituted raises its `rd_req` bit. The bit stays high until a cycle in which the matching `rd_gnt` bit is high. The data is captured at that edge and the request is low from the next cycle on.
- R6: `ops_ready` goes high in the cycle after the last outstanding grant. If no read is needed, it goes high in the cycle after issue. It stays low while any request is pending.
- R7: A slot whose `op_use` bit is 0 raises no request, holds zero and counts as satisfied.
- R8: An issue is taken only while `issue_ready` is high. `issue_ready` is high exactly when the unit is idle. An `issue_valid` pulse while busy changes neither the requests nor the slot values.
- R9: A `go` pulse while busy returns the unit to idle at the next edge. After that edge `issue_ready` is 1, `ops_ready` is 0, `rd_req` is 0 and `src_o` is 0.
- R10: After a synchronous reset the unit is idle: `issue_ready`=1, `ops_ready`=0, `rd_req`=0 and `src_o`=0.
- R11: A grant on a slot that is not requesting is ignored, and a captured slot keeps its value until `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation offered for issue |
| issue_ready | output | 1 | Unit idle; issue will be taken |
| op_zero | input | 1 | Force slot 0 to zero |
| op_imm_ok | input | 1 | Replace slot 1 with the immediate |
| op_imm | input | 64 | Immediate value |
| op_use | input | 6 | Slots used by the operation |
| rd_req | output | 6 | Per-slot register read request |
| rd_gnt | input | 6 | Per-slot read grant |
| rd_data | input | 172 | Read data, all slots packed |
| src_o | output | 172 | Collected operands, all slots packed |
| ops_ready | output | 1 | All needed operands present |
| go | input | 1 | Function unit consumed operands; release |

## Verification
Every result comes straight from a flop, so each one is due one edge after its cause. The request mask is due one edge after issue. A slot value and the fall of its request are due one edge after the grant. `ops_ready` is due one edge after the last grant, and the idle state is due one edge after `go`. The bench drives inputs on the falling edge and checks on the next falling edge, which is exactly one rising edge later. Where a request must be held, it waits extra whole cycles before granting.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int NSLOT = 6;

  // width of slot i: two integer, one condition word, three condition fields
  function automatic int slot_w(input int i, input int wi, input int wc, input int wf);
    if (i < 2)       return wi;
    else if (i == 2) return wc;
    else             return wf;
  endfunction

  function automatic int slot_off(input int i, input int wi, input int wc, input int wf);
    int acc;
    acc = 0;
    for (int j = 0; j < i; j++) acc += slot_w(j, wi, wc, wf);
    return acc;
  endfunction
endpackage

// File: rtl/opc_ctrl.sv
module opc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic issue_valid,
  input  logic go,
  input  logic all_done,
  output logic issue_fire,
  output logic release_fire,
  output logic busy,
  output logic ready
);
  logic busy_q;

  assign issue_fire   = issue_valid & ~busy_q;
  assign release_fire = go & busy_q;
  assign busy         = busy_q;
  assign ready        = busy_q & all_done;

  always_ff @(posedge clk) begin
    if (rst)               busy_q <= 1'b0;
    else if (issue_fire)   busy_q <= 1'b1;
    else if (release_fire) busy_q <= 1'b0;
  end

  // R8
  issue_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && busy_q && !go) |=> busy_q);
  // R9
  go_release_chk: assert property (@(posedge clk) disable iff (rst)
    (go && busy_q) |=> (!busy_q && !ready));
endmodule

// File: rtl/opc_slot.sv
module opc_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic         use_i,
  input  logic         sub_i,
  input  logic [W-1:0] sub_val,
  input  logic         gnt,
  input  logic [W-1:0] data,
  output logic         req,
  output logic         done,
  output logic [W-1:0] val
);
  logic         need_q;
  logic         got_q;
  logic [W-1:0] val_q;
  logic         take;

  assign req  = need_q & ~got_q;
  assign take = req & gnt;
  assign done = ~need_q | got_q;
  assign val  = val_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      need_q <= 1'b0;
      got_q  <= 1'b0;
      val_q  <= '0;
    end else if (load) begin
      need_q <= use_i & ~sub_i;
      got_q  <= 1'b0;
      val_q  <= (use_i && sub_i) ? sub_val : '0;
    end else if (take) begin
      got_q  <= 1'b1;
      val_q  <= data;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !gnt && !clear) |=> req);
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req && gnt && !clear) |=> (!req && val == $past(data)));
  // R11
  val_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (got_q && !clear) |=> $stable(val));
endmodule

// File: rtl/opc_operand_fetch.sv
module opc_operand_fetch
  import opc_pkg::*;
#(
  parameter int W_INT = 64,
  parameter int W_CR  = 32,
  parameter int W_FLD = 4,
  localparam int TOT  = slot_off(NSLOT, W_INT, W_CR, W_FLD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic             op_zero,
  input  logic             op_imm_ok,
  input  logic [W_INT-1:0] op_imm,
  input  logic [NSLOT-1:0] op_use,
  output logic [NSLOT-1:0] rd_req,
  input  logic [NSLOT-1:0] rd_gnt,
  input  logic [TOT-1:0]   rd_data,
  output logic [TOT-1:0]   src_o,
  output logic             ops_ready,
  input  logic             go
);
  logic             issue_fire;
  logic             release_fire;
  logic             busy;
  logic [NSLOT-1:0] done;
  logic             zero_q;
  logic             imm_q;

  opc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .go           (go),
    .all_done     (&done),
    .issue_fire   (issue_fire),
    .release_fire (release_fire),
    .busy         (busy),
    .ready        (ops_ready)
  );

  assign issue_ready = ~busy;

  // operation flags kept for the checks below
  always_ff @(posedge clk) begin
    if (rst || release_fire) begin
      zero_q <= 1'b0;
      imm_q  <= 1'b0;
    end else if (issue_fire) begin
      zero_q <= op_zero;
      imm_q  <= op_imm_ok;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int SW = slot_w(i, W_INT, W_CR, W_FLD);
    localparam int SO = slot_off(i, W_INT, W_CR, W_FLD);
    logic          sub;
    logic [SW-1:0] sval;

    if (i == 0) begin : g_zero
      assign sub  = op_zero;
      assign sval = '0;
    end else if (i == 1) begin : g_imm
      assign sub  = op_imm_ok;
      assign sval = op_imm[SW-1:0];
    end else begin : g_plain
      assign sub  = 1'b0;
      assign sval = '0;
    end

    opc_slot #(.W(SW)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .load    (issue_fire),
      .clear   (release_fire),
      .use_i   (op_use[i]),
      .sub_i   (sub),
      .sub_val (sval),
      .gnt     (rd_gnt[i]),
      .data    (rd_data[SO +: SW]),
      .req     (rd_req[i]),
      .done    (done[i]),
      .val     (src_o[SO +: SW])
    );
  end

  // R1
  zero_req_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (!rd_req[0] && src_o[W_INT-1:0] == '0));
  // R2
  imm_req_chk: assert property (@(posedge clk) disable iff (rst)
    imm_q |-> !rd_req[1]);
  // R6
  ready_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    ops_ready |-> (rd_req == '0));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    issue_ready |-> (rd_req == '0 && !ops_ready && src_o == '0));
endmodule

// File: tb/tb_opc_operand_fetch.sv
module tb_opc_operand_fetch;
  localparam int TOT = 172;
  localparam int NV  = 7;
  localparam int OFF [6] = '{0, 64, 128, 160, 164, 168};
  localparam int WID [6] = '{64, 64, 32, 4, 4, 4};
  // {zero, imm_ok, use[5:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b0_0_111111, 8'b1_0_111111, 8'b0_1_111111, 8'b1_1_111111,
    8'b0_0_000101, 8'b1_1_000011, 8'b0_0_000000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0, op_zero = 1'b0, op_imm_ok = 1'b0, go = 1'b0;
  logic [63:0] op_imm = '0;
  logic [5:0]  op_use = '0, rd_gnt = '0;
  logic [TOT-1:0] rd_data = '0;
  logic issue_ready, ops_ready;
  logic [5:0] rd_req;
  logic [TOT-1:0] src_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opc_operand_fetch dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .op_zero(op_zero), .op_imm_ok(op_imm_ok), .op_imm(op_imm), .op_use(op_use),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_data(rd_data), .src_o(src_o),
    .ops_ready(ops_ready), .go(go));

  task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] mk_data(input int k);
    logic [31:0] x;
    logic [TOT-1:0] d;
    x = 32'h1F2E3D4C + k;
    for (int b = 0; b < TOT; b++) begin
      x = x * 32'd1103515245 + 32'd12345;
      d[b] = x[16];
    end
    return d;
  endfunction

  function automatic logic [63:0] mk_imm(input int k);
    return 64'h1234_5678_9ABC_DEF0 ^ {32'(k), 32'(k * 7 + 1)};
  endfunction

  function automatic logic [5:0] need_of(input logic [7:0] v);
    logic [5:0] n;
    n = v[5:0];
    if (v[7]) n[0] = 1'b0;
    if (v[6]) n[1] = 1'b0;
    return n;
  endfunction

  function automatic logic [TOT-1:0] exp_src(input logic [7:0] v, input logic [TOT-1:0] d, input logic [63:0] im);
    logic [TOT-1:0] e;
    e = '0;
    for (int s = 0; s < 6; s++) begin
      if (!v[s]) continue;
      if (s == 0 && v[7]) continue;
      if (s == 1 && v[6]) begin e[63+64:64] = im; continue; end
      for (int b = 0; b < WID[s]; b++) e[OFF[s]+b] = d[OFF[s]+b];
    end
    return e;
  endfunction

  task automatic issue(input logic [7:0] v, input logic [63:0] im);
    issue_valid = 1'b1; op_zero = v[7]; op_imm_ok = v[6]; op_use = v[5:0]; op_imm = im;
    @(negedge clk);
    issue_valid = 1'b0; op_zero = 1'b0; op_imm_ok = 1'b0; op_use = '0; op_imm = '0;
  endtask

  task automatic release_unit();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk("R9 idle after go", TOT'({issue_ready, ops_ready, rd_req}), TOT'({1'b1, 1'b0, 6'b0}));
    chk("R9 src cleared", src_o, '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10
    chk("R10 reset state", TOT'({issue_ready, ops_ready, rd_req}), TOT'({1'b1, 1'b0, 6'b0}));
    chk("R10 reset src", src_o, '0);

    // vector walk: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      logic [7:0] v;
      logic [5:0] nd;
      logic [TOT-1:0] d;
      logic [63:0] im;
      v = VEC[k]; nd = need_of(v); d = mk_data(k); im = mk_imm(k);
      issue(v, im);
      chk("R5 R1 R2 R3 R7 request mask", TOT'(rd_req), TOT'(nd));
      chk("R8 busy after issue", TOT'(issue_ready), TOT'(0));
      if (k % 2 == 0 && nd != 0) begin
        repeat (2) @(negedge clk);
        chk("R5 request held without grant", TOT'(rd_req), TOT'(nd));
      end
      rd_data = d;
      for (int s = 0; s < 6; s++) begin
        if (!nd[s]) continue;
        chk("R6 not ready while pending", TOT'(ops_ready), TOT'(0));
        rd_gnt = 6'(1 << s);
        @(negedge clk);
        rd_gnt = '0;
        chk("R5 request drops after grant", TOT'(rd_req[s]), TOT'(0));
      end
      chk("R6 ready after last grant", TOT'(ops_ready), TOT'(1));
      chk("R4 R1 R2 R7 collected operands", src_o, exp_src(v, d, im));
      rd_data = '0;
      release_unit();
    end

    // R8: issue while busy is ignored
    issue(8'b0_0_111100, 64'h0);
    issue(8'b1_1_000011, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 issue while busy ignored", TOT'(rd_req), TOT'(6'b111100));
    chk("R8 slots unchanged", src_o, '0);
    // R11: grant on idle slot ignored, captured slot kept
    rd_data = {TOT{1'b1}};
    rd_gnt = 6'b000011;
    @(negedge clk);
    chk("R11 grant without request ignored", src_o, '0);
    rd_gnt = 6'b000100;
    @(negedge clk);
    rd_data = '0;
    rd_gnt = 6'b000100;
    @(negedge clk);
    rd_gnt = '0;
    chk("R11 captured slot kept", TOT'(src_o[159:128]), TOT'(32'hFFFF_FFFF));
    release_unit();

    // R3: both flags, slots 2..5 still read
    issue(8'b1_1_111111, 64'hA);
    chk("R3 other slots still requested", TOT'(rd_req), TOT'(6'b111100));
    release_unit();

    // R10: reset while busy
    issue(8'b0_0_111111, 64'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset clears busy", TOT'({issue_ready, ops_ready, rd_req}), TOT'({1'b1, 1'b0, 6'b0}));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule